// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire debug link. It performs exactly one register access per request: a read or a write, addressed either to an access port or to the debug port, at one of four word registers. A requester presents the access with a valid/ready handshake. The engine then generates the debug clock, builds the 8-bit request packet with its parity bit, turns the data line around for the target's 3-bit acknowledge, moves 32 data bits plus a parity bit in whichever direction the access needs, and finally drives a requested number of idle clocks. It reports the outcome as a single-cycle response.

The data line is split into an output value, an output enable and an input, so that a pad or a bench can resolve it. The host changes its drive only when the debug clock falls and samples the target only when the clock rises. The clock runs only while an access is in flight. Each of its half periods lasts `HALF_DIV` system clocks. A WAIT, FAULT or unrecognised acknowledge ends the access after one turnaround cycle, and the raw code is passed back. Any retry policy belongs to the requester.

Top module: `swd_host_engine`

## Requirements
- R1: The request packet goes out least significant bit first with this bit layout: bit 0 = 1 (start), bit 1 = AP select, bit 2 = read flag, bits 4:3 = `req_addr[1:0]` (register address bits 3:2), bit 5 = parity, bit 6 = 0 (stop), bit 7 = 1 (park).
- R2: Packet bit 5 is 1 exactly when bits 4:1 hold an odd number of ones, so bits 5:1 together have even parity.
- R3: `req_ready` is high only when no access is in flight. A request is taken in a cycle with `req_valid` and `req_ready` both high. Each access produces exactly one `rsp_valid` pulse of one cycle, and `req_ready` is high again in the cycle after that pulse.
- R4: After the packet, the host releases the line (`swdio_oe` = 0) for one turnaround cycle and then samples a 3-bit acknowledge least significant bit first. OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. The host never drives while the target drives.
- R5: A non-OK acknowledge ends the access after one more turnaround cycle, 13 debug clock cycles in total, with no data and no idle clocks. `rsp_ack` carries the raw code, `rsp_rdata` is 0, and `rsp_proto_err` is 1 only for codes other than the three named ones.
- R6: A read with OK samples 32 data bits least significant bit first, then one parity bit, then releases the line for one turnaround cycle. `rsp_rdata` returns the data, and `rsp_perr` is 1 exactly when the data bits plus the parity bit have an odd number of ones.
- R7: A write with OK spends one turnaround cycle with the line released after the acknowledge, then drives the 32 data bits least significant bit first, followed by an even-parity bit.
- R8: After a successful access the host drives `req_idle` extra clock cycles with the line low. A successful access therefore lasts 46 + `req_idle` debug clock cycles.
- R9: `swdio_out` and `swdio_oe` change only in the system cycle where `swclk` falls, or when a request is taken. The debug clock period is 2 x `HALF_DIV` system clocks, and `swclk` stays low while the engine is ready.
- R10: After reset `req_ready` = 1, `swclk` = 0, `swdio_oe` = 1, `swdio_out` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| req_idle | input | 8 | Idle clocks appended after a successful access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data (0 unless a read with OK) |
| rsp_ack | output | 3 | Raw acknowledge code |
| rsp_perr | output | 1 | Read data parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was not OK, WAIT or FAULT |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when 1 |
| swdio_in | input | 1 | Resolved data line level |

## Verification
The embedded properties check on every cycle that the line drive moves only on a falling debug clock edge or on request acceptance. They also check that the line is released for the whole acknowledge, that the clock is parked low while the engine is ready, that every response is a single-cycle pulse, that only OK reads can flag a parity error, and that failed accesses return no data. Packet bit order and parity, data bit order in both directions, the exact length of each access path, idle-tail counts and the absence of drive contention depend on what a target returns. Only the bench's scripted target model shows these, including a read whose parity bit is corrupted.

// File: rtl/swdh_pkg.sv
`timescale 1ns/1ps
package swdh_pkg;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;
    localparam int         PKT_BITS  = 8;

    typedef enum logic [3:0] {
        PH_IDLE, PH_REQ, PH_TRN1, PH_ACK, PH_TRN2,
        PH_RDATA, PH_RPAR, PH_TRN3, PH_WDATA, PH_WPAR,
        PH_TAIL, PH_FINISH
    } phase_e;

    typedef struct packed {
        logic       rnw;
        logic       ap;
        logic [1:0] addr;
    } hdr_t;

    function automatic logic ack_known(input logic [2:0] a);
        return (a == ACK_OK) || (a == ACK_WAIT) || (a == ACK_FAULT);
    endfunction

endpackage

// File: rtl/swdh_clk_div.sv
`timescale 1ns/1ps
module swdh_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic swclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_stb = wrap && !swclk;
    assign fall_stb = wrap && swclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            swclk <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            swclk <= ~swclk;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R9: each strobe is followed by the matching clock level
    p_rise_sets_high_r9: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> swclk);
endmodule

// File: rtl/swdh_pkt_build.sv
`timescale 1ns/1ps
module swdh_pkt_build
    import swdh_pkg::*;
(
    input  hdr_t                hdr,
    output logic [PKT_BITS-1:0] pkt
);
    logic par;

    assign par = ^{hdr.addr, hdr.rnw, hdr.ap};
    assign pkt = {1'b1, 1'b0, par, hdr.addr[1], hdr.addr[0], hdr.rnw, hdr.ap, 1'b1};
endmodule

// File: rtl/swdh_seq.sv
`timescale 1ns/1ps
module swdh_seq
    import swdh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  hdr_t                hdr,
    input  logic [PKT_BITS-1:0] pkt,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDLE_W-1:0]   idle,
    input  logic                rise_stb,
    input  logic                fall_stb,
    output logic                busy,
    input  logic                swdio_in,
    output logic                swdio_out,
    output logic                swdio_oe,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [2:0]          rsp_ack,
    output logic                rsp_perr,
    output logic                rsp_proto_err
);
    localparam int BCW = ($clog2(DATA_W) > 3) ? $clog2(DATA_W) : 3;

    phase_e                ph;
    logic [BCW-1:0]        bcnt;
    logic [IDLE_W-1:0]     tail, idle_q;
    logic [PKT_BITS-1:0]   pkt_q;
    logic [DATA_W-1:0]     wdata_q, rdata_q;
    logic [2:0]            ack_q, ack_full;
    logic                  rnw_q, par_q, accept, read_ok;

    assign req_ready = (ph == PH_IDLE);
    assign busy      = !req_ready;
    assign accept    = req_valid && req_ready;
    assign ack_full  = {swdio_in, ack_q[1:0]};
    assign read_ok   = rnw_q && (ack_q == ACK_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph            <= PH_IDLE;
            bcnt          <= '0;
            tail          <= '0;
            idle_q        <= '0;
            pkt_q         <= '0;
            wdata_q       <= '0;
            rdata_q       <= '0;
            ack_q         <= '0;
            rnw_q         <= 1'b0;
            par_q         <= 1'b0;
            swdio_out     <= 1'b0;
            swdio_oe      <= 1'b1;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            rsp_ack       <= '0;
            rsp_perr      <= 1'b0;
            rsp_proto_err <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                pkt_q     <= pkt;
                wdata_q   <= wdata;
                idle_q    <= idle;
                rnw_q     <= hdr.rnw;
                bcnt      <= '0;
                swdio_out <= pkt[0];
                swdio_oe  <= 1'b1;
                ph        <= PH_REQ;
            end else if (rise_stb) begin
                unique case (ph)
                    PH_REQ: begin
                        if (bcnt == BCW'(PKT_BITS - 1)) ph <= PH_TRN1;
                        else bcnt <= bcnt + 1'b1;
                    end
                    PH_TRN1: begin
                        bcnt <= '0;
                        ph   <= PH_ACK;
                    end
                    PH_ACK: begin
                        ack_q[bcnt[1:0]] <= swdio_in;
                        if (bcnt == BCW'(2)) begin
                            bcnt <= '0;
                            ph   <= (ack_full == ACK_OK && rnw_q) ? PH_RDATA : PH_TRN2;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    PH_TRN2: ph <= (ack_q == ACK_OK) ? PH_WDATA : PH_FINISH;
                    PH_RDATA: begin
                        rdata_q[bcnt] <= swdio_in;
                        if (bcnt == BCW'(DATA_W - 1)) ph <= PH_RPAR;
                        else bcnt <= bcnt + 1'b1;
                    end
                    PH_RPAR: begin
                        par_q <= swdio_in;
                        ph    <= PH_TRN3;
                    end
                    PH_WDATA: begin
                        if (bcnt == BCW'(DATA_W - 1)) ph <= PH_WPAR;
                        else bcnt <= bcnt + 1'b1;
                    end
                    PH_TRN3, PH_WPAR: begin
                        tail <= idle_q;
                        ph   <= (idle_q == '0) ? PH_FINISH : PH_TAIL;
                    end
                    PH_TAIL: begin
                        if (tail == IDLE_W'(1)) ph <= PH_FINISH;
                        else tail <= tail - 1'b1;
                    end
                    default: ;
                endcase
            end else if (fall_stb) begin
                unique case (ph)
                    PH_REQ: begin
                        swdio_out <= pkt_q[bcnt[2:0]];
                        swdio_oe  <= 1'b1;
                    end
                    PH_WDATA: begin
                        swdio_out <= wdata_q[bcnt];
                        swdio_oe  <= 1'b1;
                    end
                    PH_WPAR: begin
                        swdio_out <= ^wdata_q;
                        swdio_oe  <= 1'b1;
                    end
                    PH_TAIL: begin
                        swdio_out <= 1'b0;
                        swdio_oe  <= 1'b1;
                    end
                    PH_FINISH: begin
                        swdio_out     <= 1'b0;
                        swdio_oe      <= 1'b1;
                        ph            <= PH_IDLE;
                        rsp_valid     <= 1'b1;
                        rsp_ack       <= ack_q;
                        rsp_proto_err <= !ack_known(ack_q);
                        rsp_rdata     <= read_ok ? rdata_q : '0;
                        rsp_perr      <= read_ok && (par_q != ^rdata_q);
                    end
                    default: swdio_oe <= 1'b0;
                endcase
            end
        end
    end

    // R9: line drive moves only on a falling debug clock or on acceptance
    p_drive_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !(fall_stb || accept) |=> ($stable(swdio_out) && $stable(swdio_oe)));
    // R4: host never drives while the acknowledge is on the line
    p_release_for_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ACK) |-> !swdio_oe);
    // R3: responses are single-cycle pulses
    p_rsp_single_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R6: a parity error is only possible on an OK access
    p_perr_only_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_perr) |-> (rsp_ack == ACK_OK));
    // R5: failed accesses return no data
    p_no_data_on_fail_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ack != ACK_OK) |-> (rsp_rdata == '0));
endmodule

// File: rtl/swd_host_engine.sv
`timescale 1ns/1ps
module swd_host_engine
    import swdh_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 32,
    parameter int IDLE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rnw,
    input  logic              req_ap,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [IDLE_W-1:0] req_idle,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [2:0]        rsp_ack,
    output logic              rsp_perr,
    output logic              rsp_proto_err,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    hdr_t                hdr;
    logic [PKT_BITS-1:0] pkt;
    logic                busy, rise_stb, fall_stb;

    assign hdr = '{rnw: req_rnw, ap: req_ap, addr: req_addr};

    swdh_pkt_build u_pkt (.hdr(hdr), .pkt(pkt));

    swdh_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst(rst), .run(busy),
        .swclk(swclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    swdh_seq #(.DATA_W(DATA_W), .IDLE_W(IDLE_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .hdr(hdr), .pkt(pkt), .wdata(req_wdata), .idle(req_idle),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .busy(busy),
        .swdio_in(swdio_in), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
        .rsp_perr(rsp_perr), .rsp_proto_err(rsp_proto_err)
    );

    // R9: debug clock parked low whenever a new request can be taken
    p_clk_parked_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !swclk);
endmodule

// File: tb/swd_host_engine_test.sv
`timescale 1ns/1ps
module swd_host_engine_test;
    localparam int HALF_DIV = 2;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_rnw = 1'b0, req_ap = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_idle = '0;
    logic        req_ready, rsp_valid, rsp_perr, rsp_proto_err;
    logic [31:0] rsp_rdata;
    logic [2:0]  rsp_ack;
    logic        swclk, swdio_out, swdio_oe, swdio_in;
    logic        tgt_oe = 1'b0, tgt_out = 1'b0;

    int n_chk = 0, n_fail = 0, rise_cnt = 0, viol = 0, clash = 0;
    logic p_out = 1'b0, p_oe = 1'b1;

    always #4 clk = ~clk;

    assign swdio_in = swdio_oe ? swdio_out : (tgt_oe ? tgt_out : 1'b1);

    swd_host_engine #(.HALF_DIV(HALF_DIV)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rnw(req_rnw), .req_ap(req_ap), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_idle(req_idle),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
        .rsp_perr(rsp_perr), .rsp_proto_err(rsp_proto_err),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    always @(posedge swclk) rise_cnt++;

    always @(negedge clk) begin
        if (!rst && swclk && (swdio_out !== p_out || swdio_oe !== p_oe)) viol++;
        if (swdio_oe && tgt_oe) clash++;
        p_out = swdio_out;
        p_oe  = swdio_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pkt(input logic rnw, input logic ap, input logic [1:0] a);
        return {1'b1, 1'b0, ^{a, rnw, ap}, a[1], a[0], rnw, ap, 1'b1};
    endfunction

    // Scripted target: records packet and write data, returns ack/data
    task automatic target(input logic rnw, input logic [2:0] ack, input logic [31:0] rd,
                          input logic flip, output logic [7:0] pkt, output logic [31:0] wd,
                          output logic wpar, output logic trn_ok);
        trn_ok = 1'b1; wd = '0; wpar = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge swclk); pkt[i] = swdio_out;
            if (!swdio_oe) trn_ok = 1'b0;
        end
        @(posedge swclk); if (swdio_oe) trn_ok = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge swclk); tgt_oe = 1'b1; tgt_out = ack[i];
            @(posedge swclk);
        end
        if (ack == 3'b001 && rnw) begin
            for (int i = 0; i < 32; i++) begin
                @(negedge swclk); tgt_out = rd[i];
                @(posedge swclk);
            end
            @(negedge swclk); tgt_out = (^rd) ^ flip;
            @(posedge swclk);
            @(negedge swclk); tgt_oe = 1'b0;
            @(posedge swclk); if (swdio_oe) trn_ok = 1'b0;
        end else begin
            @(negedge swclk); tgt_oe = 1'b0;
            @(posedge swclk); if (swdio_oe) trn_ok = 1'b0;
            if (ack == 3'b001) begin
                for (int i = 0; i < 32; i++) begin
                    @(posedge swclk); wd[i] = swdio_out;
                    if (!swdio_oe) trn_ok = 1'b0;
                end
                @(posedge swclk); wpar = swdio_out;
            end
        end
    endtask

    task automatic do_txn(input logic rnw, input logic ap, input logic [1:0] a,
                          input logic [31:0] wdat, input logic [7:0] idl,
                          input logic [2:0] ack, input logic [31:0] rd, input logic flip,
                          output logic [7:0] pkt, output logic [31:0] wd, output logic wpar,
                          output logic trn_ok, output int rises);
        int guard = 0;
        rise_cnt = 0;
        @(negedge clk);
        req_rnw = rnw; req_ap = ap; req_addr = a; req_wdata = wdat; req_idle = idl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 busy after accept", {31'd0, req_ready}, 32'd0);
        target(rnw, ack, rd, flip, pkt, wd, wpar, trn_ok);
        while (!rsp_valid && guard < 5000) begin
            @(negedge clk); guard++;
        end
        rises = rise_cnt;
        chk("R3 response seen", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'd0, rsp_valid}, 32'd0);
        chk("R3 ready after response", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R10 ready", {31'd0, req_ready}, 32'd1);
        chk("R10 swclk", {31'd0, swclk}, 32'd0);
        chk("R10 oe", {31'd0, swdio_oe}, 32'd1);
        chk("R10 out", {31'd0, swdio_out}, 32'd0);
        chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_ap_write_ok();
        logic [7:0] pkt; logic [31:0] wd; logic wpar, ok; int r;
        realtime t0, t1;
        fork
            do_txn(1'b0, 1'b1, 2'b01, 32'hA5C3_0F96, 8'd3, 3'b001, 32'h0, 1'b0, pkt, wd, wpar, ok, r);
            begin
                @(posedge swclk); t0 = $realtime;
                @(posedge swclk); t1 = $realtime;
            end
        join
        chk("R9 period", 32'(int'(t1 - t0)), 32'(2 * HALF_DIV * 8));
        chk("R1 write packet", {24'd0, pkt}, {24'd0, exp_pkt(1'b0, 1'b1, 2'b01)});
        chk("R2 parity bit", {31'd0, pkt[5]}, {31'd0, ^pkt[4:1]});
        chk("R4 turnarounds", {31'd0, ok}, 32'd1);
        chk("R7 write data", wd, 32'hA5C3_0F96);
        chk("R7 write parity", {31'd0, wpar}, {31'd0, ^32'hA5C3_0F96});
        chk("R8 cycle count", 32'(r), 32'd49);
        chk("R4 ack OK", {29'd0, rsp_ack}, 32'd1);
        chk("R8 line low after tail", {30'd0, swdio_oe, swdio_out}, 32'd2);
    endtask

    task automatic t_ap_read_ok();
        logic [7:0] pkt; logic [31:0] wd; logic wpar, ok; int r;
        do_txn(1'b1, 1'b1, 2'b11, '0, 8'd2, 3'b001, 32'h1234_5678, 1'b0, pkt, wd, wpar, ok, r);
        chk("R1 read packet", {24'd0, pkt}, {24'd0, exp_pkt(1'b1, 1'b1, 2'b11)});
        chk("R6 read data", rsp_rdata, 32'h1234_5678);
        chk("R6 no parity error", {31'd0, rsp_perr}, 32'd0);
        chk("R6 turnaround", {31'd0, ok}, 32'd1);
        chk("R8 read cycle count", 32'(r), 32'd48);
    endtask

    task automatic t_read_bad_parity();
        logic [7:0] pkt; logic [31:0] wd; logic wpar, ok; int r;
        do_txn(1'b1, 1'b0, 2'b00, '0, 8'd0, 3'b001, 32'hDEAD_BEEF, 1'b1, pkt, wd, wpar, ok, r);
        chk("R2 dp read packet", {24'd0, pkt}, {24'd0, exp_pkt(1'b1, 1'b0, 2'b00)});
        chk("R6 parity error flagged", {31'd0, rsp_perr}, 32'd1);
        chk("R6 data still returned", rsp_rdata, 32'hDEAD_BEEF);
        chk("R8 zero idle count", 32'(r), 32'd46);
    endtask

    task automatic t_fail_ack(input string tag, input logic rnw, input logic [2:0] ack,
                              input logic proto);
        logic [7:0] pkt; logic [31:0] wd; logic wpar, ok; int r;
        do_txn(rnw, 1'b1, 2'b10, 32'hFFFF_0000, 8'd5, ack, 32'hCAFE_F00D, 1'b0, pkt, wd, wpar, ok, r);
        chk({"R5 ", tag, " ack"}, {29'd0, rsp_ack}, {29'd0, ack});
        chk({"R5 ", tag, " length"}, 32'(r), 32'd13);
        chk({"R5 ", tag, " no data"}, rsp_rdata, 32'd0);
        chk({"R5 ", tag, " proto flag"}, {31'd0, rsp_proto_err}, {31'd0, proto});
        chk({"R4 ", tag, " turnarounds"}, {31'd0, ok}, 32'd1);
    endtask

    task automatic t_dp_write_no_idle();
        logic [7:0] pkt; logic [31:0] wd; logic wpar, ok; int r;
        do_txn(1'b0, 1'b0, 2'b10, 32'h0000_0001, 8'd0, 3'b001, '0, 1'b0, pkt, wd, wpar, ok, r);
        chk("R1 dp write packet", {24'd0, pkt}, {24'd0, exp_pkt(1'b0, 1'b0, 2'b10)});
        chk("R7 dp write data", wd, 32'h0000_0001);
        chk("R7 dp write parity", {31'd0, wpar}, 32'd1);
        chk("R8 no tail", 32'(r), 32'd46);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ap_write_ok();
        t_ap_read_ok();
        t_read_bad_parity();
        t_fail_ack("wait", 1'b0, 3'b010, 1'b0);
        t_fail_ack("fault", 1'b1, 3'b100, 1'b0);
        t_fail_ack("bad code", 1'b1, 3'b111, 1'b1);
        t_dp_write_no_idle();
        chk("R9 drive only on falling edge", 32'(viol), 32'd0);
        chk("R4 no line contention", 32'(clash), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule